// File: doc/BRIEF.md
# Transmit Interrupt Mask and Status Unit

This unit collects the interrupt sources of an audio transmit peripheral and turns them into one level interrupt line. Each source occupies one fixed bit position. Some sources are levels that follow their input directly. The others are events: a one-cycle pulse on such an input latches a flag that stays set until software reads the status register.

Software controls which sources can raise the interrupt through a mask, and never writes the mask directly. Writing ones to a set register enables the matching sources. Writing ones to a clear register disables them. The mask itself can only be read.

A software reset strobe wipes the mask. The interrupt output is the registered OR of every status bit whose mask bit is set. The register port is a plain 32-bit port: a write strobe and a read strobe, both sharing one byte offset.

Top module: `tx_irq_ctrl`

## Requirements
- R1: After reset the mask is 0, every latched event flag is 0 and `irq` is 0.
- R2: A write to offset 0x14 sets each mask bit whose data bit is 1. Data bits that are 0, and data bits 31:14, leave the mask unchanged.
- R3: A write to offset 0x18 clears each mask bit whose data bit is 1, and a write of 0xFFFFFFFF there clears the whole mask.
- R4: A read at offset 0x1C returns the mask in bits 13:0 and zeros above them. Writes to offset 0x1C or offset 0x20 change neither the mask nor the status.
- R5: A read at offset 0x20 returns the status in bits 13:0. Bits 0, 1, 2, 3, 8 and 9 show the current level of their source. Bits 4, 5, 6, 7, 10, 11, 12 and 13 are event flags, set by a high source and held after the source falls.
- R6: A status read clears every event flag after it returns its value. Level bits are not affected by the read.
- R7: An event that arrives in the same cycle as a status read is not lost. It reads as set on the next status read.
- R8: `irq` goes high one clock after any status bit and its mask bit are both 1, and it goes low one clock after no such pair remains. An unmasked source never raises it.
- R9: A cycle with `swReset` high clears the mask, and this takes precedence over a set-register write in the same cycle.
- R10: Reads at any offset other than 0x1C and 0x20 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte offset for the read or the write |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe (the side effect happens at the clock edge) |
| regRdData | output | 32 | Read data for the current offset, combinational |
| swReset | input | 1 | Software reset command; clears the mask |
| srcEvent | input | 14 | Source inputs, one per status bit position |
| irq | output | 1 | Level interrupt output |

## Verification
The mask is built up and torn down through patterns that mix one and zero bits. This separates a true read-modify-write from a plain overwrite, and all-ones on the clear register checks the full wipe. Event pulses are compared with held level sources, so a sticky flag can be told apart from a live level, and a read that clears too much can be told apart from one that clears too little. A pulse placed exactly on a status read checks set-over-clear priority. Masked and unmasked events confirm both the one-clock latency and the gating of `irq`.

// File: rtl/tx_irq_pkg.sv
package tx_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NUM_SRC = 14;

  // register offsets (software visible, fixed)
  localparam logic [ADDR_W-1:0] OFS_SET    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h20;

  // 1 = level source, 0 = latched event
  localparam logic [NUM_SRC-1:0] LEVEL_BITS = 14'b00_0011_0000_1111;

  typedef struct packed {
    logic setMask;
    logic clrMask;
    logic wipeMask;
    logic clrFlags;
  } irq_strobe_t;
endpackage

// File: rtl/tx_irq_regif.sv
module tx_irq_regif
  import tx_irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NS = NUM_SRC
) (
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  input  logic          regRdEn,
  input  logic          swReset,
  input  logic [NS-1:0] maskQ,
  input  logic [NS-1:0] statusNow,
  output irq_strobe_t   strobes,
  output logic [NS-1:0] wrBits,
  output logic [DW-1:0] regRdData
);
  logic unusedHiBits;
  assign unusedHiBits = ^regWrData[DW-1:NS];
  assign wrBits = regWrData[NS-1:0];

  always_comb begin
    strobes.wipeMask = swReset;
    strobes.setMask  = regWrEn && (regAddr == AW'(OFS_SET));
    strobes.clrMask  = regWrEn && (regAddr == AW'(OFS_CLR));
    strobes.clrFlags = regRdEn && (regAddr == AW'(OFS_STATUS));
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == AW'(OFS_MASK))        regRdData = DW'(maskQ);
    else if (regAddr == AW'(OFS_STATUS)) regRdData = DW'(statusNow);
  end
endmodule

// File: rtl/tx_irq_core.sv
module tx_irq_core
  import tx_irq_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter logic [NS-1:0] LEVEL_MASK = LEVEL_BITS
) (
  input  logic          clk,
  input  logic          rstN,
  input  irq_strobe_t   strobes,
  input  logic [NS-1:0] wrBits,
  input  logic [NS-1:0] srcEvent,
  output logic [NS-1:0] maskQ,
  output logic [NS-1:0] statusNow,
  output logic          irq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 maskQ <= '0;
    else if (strobes.wipeMask) maskQ <= '0;
    else if (strobes.setMask)  maskQ <= maskQ | wrBits;
    else if (strobes.clrMask)  maskQ <= maskQ & ~wrBits;
  end

  for (genvar i = 0; i < NS; i++) begin : g_bit
    if (LEVEL_MASK[i]) begin : g_level
      assign statusNow[i] = srcEvent[i];
    end else begin : g_flag
      logic flagQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagQ <= 1'b0;
        else       flagQ <= (flagQ && !strobes.clrFlags) || srcEvent[i];
      end
      assign statusNow[i] = flagQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(statusNow & maskQ);
  end
endmodule

// File: rtl/tx_irq_ctrl.sv
module tx_irq_ctrl
  import tx_irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NS = NUM_SRC
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  input  logic          regRdEn,
  output logic [DW-1:0] regRdData,
  input  logic          swReset,
  input  logic [NS-1:0] srcEvent,
  output logic          irq
);
  irq_strobe_t   strobes;
  logic [NS-1:0] wrBits;
  logic [NS-1:0] maskQ;
  logic [NS-1:0] statusNow;

  tx_irq_regif #(.AW(AW), .DW(DW), .NS(NS)) i_regif (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .swReset(swReset), .maskQ(maskQ),
    .statusNow(statusNow), .strobes(strobes), .wrBits(wrBits),
    .regRdData(regRdData)
  );

  tx_irq_core #(.NS(NS), .LEVEL_MASK(NS'(LEVEL_BITS))) i_core (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrBits(wrBits),
    .srcEvent(srcEvent), .maskQ(maskQ), .statusNow(statusNow), .irq(irq)
  );
endmodule

// File: rtl/tx_irq_ctrl_chk.sv
module tx_irq_ctrl_chk
  import tx_irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NS = NUM_SRC
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] regAddr,
  input logic          regWrEn,
  input logic [DW-1:0] regWrData,
  input logic          regRdEn,
  input logic          swReset,
  input logic [NS-1:0] maskQ,
  input logic [NS-1:0] statusNow,
  input logic          irq
);
  localparam logic [NS-1:0] EVT = ~NS'(LEVEL_BITS);
  logic wrSet, wrClr, rdSt;
  assign wrSet = regWrEn && regAddr == AW'(OFS_SET);
  assign wrClr = regWrEn && regAddr == AW'(OFS_CLR);
  assign rdSt  = regRdEn && regAddr == AW'(OFS_STATUS);

  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    (wrSet && !swReset) |=> ((maskQ & $past(regWrData[NS-1:0])) == $past(regWrData[NS-1:0])));
  a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr && !swReset) |=> ((maskQ & $past(regWrData[NS-1:0])) == '0));
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wrSet && !wrClr && !swReset) |=> $stable(maskQ));
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdSt |=> ((statusNow & $past(statusNow) & EVT) == ($past(statusNow) & EVT)));
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(|(statusNow & maskQ))));
  a_r9_wipe: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (maskQ == '0));
endmodule

bind tx_irq_ctrl tx_irq_ctrl_chk #(.AW(AW), .DW(DW), .NS(NS)) i_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdEn(regRdEn), .swReset(swReset),
  .maskQ(maskQ), .statusNow(statusNow), .irq(irq)
);

// File: tb/test_tx_irq_ctrl.sv
`timescale 1ns/1ps
module test_tx_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic        swReset = 1'b0;
  logic [13:0] srcEvent = '0;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tx_irq_ctrl i_tx_irq_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .swReset(swReset), .srcEvent(srcEvent), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulse(logic [13:0] bits);
    @(negedge clk);
    srcEvent = bits;
    @(negedge clk);
    srcEvent = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    regRead(8'h1C, d); check("R1 mask", d, 32'h0);
    regRead(8'h20, d); check("R1 status", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set;
    logic [31:0] d;
    regWrite(8'h14, 32'h0000_0031);
    regRead(8'h1C, d); check("R2 set", d, 32'h31);
    regWrite(8'h14, 32'hFFFF_0100);
    regRead(8'h1C, d); check("R2 accumulate", d, 32'h131);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    regWrite(8'h18, 32'h0000_0011);
    regRead(8'h1C, d); check("R3 clear", d, 32'h120);
    regWrite(8'h18, 32'hFFFF_FFFF);
    regRead(8'h1C, d); check("R3 all ones", d, 32'h0);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    regWrite(8'h1C, 32'h0000_3FFF);
    regWrite(8'h20, 32'h0000_3FFF);
    regRead(8'h1C, d); check("R4 mask ro", d, 32'h0);
    regRead(8'h20, d); check("R4 status ro", d, 32'h0);
  endtask

  task automatic t_level_flag;
    logic [31:0] d;
    pulse(14'h0012);
    regRead(8'h20, d); check("R5 flag held, level gone", d, 32'h10);
    @(negedge clk); srcEvent = 14'h0002;
    regRead(8'h20, d); check("R6 flag cleared, level live", d, 32'h2);
    regRead(8'h20, d); check("R6 level kept", d, 32'h2);
    @(negedge clk); srcEvent = '0;
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk);
    regAddr = 8'h20; regRdEn = 1'b1; srcEvent = 14'h0020;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; srcEvent = '0;
    check("R7 first read", d, 32'h0);
    regRead(8'h20, d); check("R7 event kept", d, 32'h20);
    regRead(8'h20, d); check("R7 then cleared", d, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    regWrite(8'h14, 32'h0000_2000);
    pulse(14'h2000);
    check("R8 latency low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    regRead(8'h20, d); check("R8 status", d, 32'h2000);
    @(negedge clk);
    check("R8 irq drops", {31'b0, irq}, 32'h0);
    pulse(14'h0010);
    @(negedge clk);
    check("R8 unmasked quiet", {31'b0, irq}, 32'h0);
    regRead(8'h20, d);
  endtask

  task automatic t_swreset;
    logic [31:0] d;
    regWrite(8'h14, 32'h3);
    @(negedge clk);
    regAddr = 8'h14; regWrData = 32'h4; regWrEn = 1'b1; swReset = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; swReset = 1'b0;
    regRead(8'h1C, d); check("R9 wipe wins", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    regWrite(8'h14, 32'h5);
    regRead(8'h00, d); check("R10 off 00", d, 32'h0);
    regRead(8'h24, d); check("R10 off 24", d, 32'h0);
    regRead(8'h14, d); check("R10 off 14", d, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        t_reset; t_set; t_clear; t_readonly; t_level_flag;
        t_collide; t_irq; t_swreset; t_unmapped;
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule